// File: doc/BRIEF.md
# Multi-Channel ADC Read Sequencer

This block is an SPI master that fetches one conversion result from a chosen input of a multi-channel successive-approximation converter. The converter has a two-deep configuration pipeline. A configuration word written in one transfer governs the acquisition that follows that transfer, and that result only appears on the serial data line two transfers later. The sequencer hides this from the host. It keeps a shadow of the 14-bit configuration register and rewrites only the 3-bit input-select field. When the requested input differs from the previous one, it adds a second configuration transfer. It then clocks the result out with a zero data word.

The host offers a channel number with a valid/ready handshake and receives a one-cycle response pulse that carries the result or an error flag. Every transfer is framed by an active-low chip select. Each is followed by an idle gap whose length is computed from the system clock frequency and a time in nanoseconds. After reset the block programs the converter with a fixed configuration and performs two throw-away reads of input 0. Only then does it accept requests.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset, the block keeps `req_ready` low and performs five transfers: the full configuration 0x3C79, then two reads of input 0, each read being one configuration word followed by one zero word. It then raises `req_ready`.
- R2: A request for the same input as the last completed read produces exactly two transfers: one configuration word and then one zero word.
- R3: A request for a different input produces exactly three transfers: two identical configuration words and then one zero word.
- R4: Each configuration word is the shadow value 0x3C79 with bits 9..7 replaced by the requested input number and all other bits unchanged. The 14 bits are left-justified in the RES_BITS-wide word, so the low RES_BITS-14 bits are zero.
- R5: Each transfer is framed by `spi_cs_n` low and uses SPI mode 0. `spi_sclk` idles low and MISO is sampled on its rising edge. Each transfer has exactly RES_BITS clock pulses, sent MSB first.
- R6: Between the end of one transfer and the start of the next, `spi_cs_n` stays high for at least GAP_CYC system clock cycles, where GAP_CYC = ceil(SYS_CLK_HZ·GAP_NS/1e9).
- R7: `rsp_data` equals the word shifted in on MISO during the final (zero) transfer of the read. With a converter that applies its configuration as described, this is a sample of the requested input.
- R8: A request for an input number ≥ NUM_CH is answered with `rsp_valid` and `rsp_err` high in the cycle after acceptance, and starts no transfer.
- R9: `req_ready` is low from acceptance until the response. `req_valid` is ignored while `req_ready` is low, so no extra transfer and no extra response occur. `rsp_valid` is a single-cycle pulse.
- R10: The last-input record is updated only when a data transfer completes. A rejected request leaves it unchanged, so a following request for the previously read input takes two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a read request |
| req_ch | input | 3 | Requested input number |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a rejection of an out-of-range input |
| rsp_data | output | RES_BITS | Conversion result |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with RES_BITS=16, NUM_CH=6, SCLK_DIV=2 and a 20 ns gap at 250 MHz, which gives GAP_CYC=5. The 16-bit word exercises the two-bit left justification. NUM_CH=6 leaves inputs 6 and 7 of the 3-bit field as out-of-range codes. A converter model with the two-transfer latency tags every sample with the input it was acquired on. A sweep over every ordered pair of previous and next input, including the rejected codes, therefore exposes any stale-channel result, any wrong transfer count and any corruption of the shadow word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W     = 14;
    localparam int SEL_LSB   = 7;
    localparam int SEL_W     = 3;

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [SEL_W-1:0] sel_t;

    localparam cfg_t SEL_MASK  = 14'h0380;
    localparam cfg_t BOOT_CFG  = 14'h3C79;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_state_t;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_CFG,
        SQ_DATA,
        SQ_IDLE
    } seq_state_t;

    // Replace the masked bits of a register image with new content.
    function automatic cfg_t cfg_merge(input cfg_t old_v, input cfg_t new_v, input cfg_t mask);
        return (new_v & mask) | (old_v & ~mask);
    endfunction

    // Number of clock cycles that cover a time span, rounded up.
    function automatic int span_cycles(input int clk_hz, input int span_ns);
        int c;
        c = ((clk_hz / 1000) * span_ns + 999_999) / 1_000_000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_cfg_shadow.sv
module adc_cfg_shadow
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic merge_en,
    input  sel_t merge_sel,
    output cfg_t cfg_q
);
    cfg_t placed;

    assign placed = cfg_t'(merge_sel) << SEL_LSB;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= BOOT_CFG;
        end else if (merge_en) begin
            cfg_q <= cfg_merge(cfg_q, placed, SEL_MASK);
        end
    end
endmodule

// File: rtl/adc_spi_word.sv
module adc_spi_word
    import adc_seq_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 2,
    parameter int GAP = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         cs_n,
    output logic         mosi,
    input  logic         miso
);
    localparam int DIV_W = $clog2(DIV + 1);
    localparam int BIT_W = $clog2(W);
    localparam int GAP_W = $clog2(GAP + 1);

    eng_state_t       st;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;
    logic [GAP_W-1:0] gap_q;
    logic [W-1:0]     tx_q;
    logic [W-1:0]     rx_q;

    assign mosi    = ~cs_n & tx_q[W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ENG_IDLE;
            div_q <= '0;
            bit_q <= '0;
            gap_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st    <= ENG_SHIFT;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b0;
                        tx_q  <= tx_word;
                        div_q <= '0;
                        bit_q <= '0;
                    end
                end
                ENG_SHIFT: begin
                    if (div_q == DIV_W'(DIV - 1)) begin
                        div_q <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rx_q <= {rx_q[W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bit_q == BIT_W'(W - 1)) begin
                                cs_n  <= 1'b1;
                                gap_q <= '0;
                                st    <= ENG_GAP;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                                tx_q  <= tx_q << 1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ENG_GAP: begin
                    if (gap_q == GAP_W'(GAP - 1)) begin
                        done <= 1'b1;
                        st   <= ENG_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 16,
    parameter int NUM_CH   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  sel_t                req_ch,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [RES_BITS-1:0] rsp_data,
    output logic                xfer_start,
    output logic                xfer_zero,
    input  logic                xfer_done,
    input  logic [RES_BITS-1:0] xfer_rx,
    output logic                merge_en,
    output sel_t                merge_sel
);
    seq_state_t st;
    logic       launched;
    logic [1:0] cfg_left;
    logic [1:0] boot_left;
    sel_t       last_sel;
    sel_t       cur_sel;
    logic       in_range;

    assign in_range   = int'(req_ch) < NUM_CH;
    assign req_ready  = (st == SQ_IDLE);
    assign xfer_start = (st != SQ_IDLE) && !launched;
    assign xfer_zero  = (st == SQ_DATA);
    assign merge_en   = (st == SQ_IDLE) && req_valid && in_range;
    assign merge_sel  = req_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_BOOT;
            launched  <= 1'b0;
            cfg_left  <= 2'd0;
            boot_left <= 2'd2;
            last_sel  <= '0;
            cur_sel   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (xfer_start) begin
                launched <= 1'b1;
            end
            unique case (st)
                SQ_BOOT: begin
                    if (xfer_done) begin
                        launched <= 1'b0;
                        cfg_left <= 2'd1;
                        st       <= SQ_CFG;
                    end
                end
                SQ_CFG: begin
                    if (xfer_done) begin
                        launched <= 1'b0;
                        cfg_left <= cfg_left - 1'b1;
                        if (cfg_left == 2'd1) begin
                            st <= SQ_DATA;
                        end
                    end
                end
                SQ_DATA: begin
                    if (xfer_done) begin
                        launched <= 1'b0;
                        last_sel <= cur_sel;
                        if (boot_left != 2'd0) begin
                            boot_left <= boot_left - 1'b1;
                            if (boot_left == 2'd2) begin
                                cfg_left <= 2'd1;
                                st       <= SQ_CFG;
                            end else begin
                                st <= SQ_IDLE;
                            end
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_data  <= xfer_rx;
                            st        <= SQ_IDLE;
                        end
                    end
                end
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (!in_range) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_data  <= '0;
                        end else begin
                            cur_sel  <= req_ch;
                            cfg_left <= (req_ch == last_sel) ? 2'd1 : 2'd2;
                            st       <= SQ_CFG;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS   = 16,
    parameter int NUM_CH     = 8,
    parameter int SCLK_DIV   = 2,
    parameter int SYS_CLK_HZ = 250_000_000,
    parameter int GAP_NS     = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [2:0]          req_ch,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [RES_BITS-1:0] rsp_data,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int GAP_CYC   = span_cycles(SYS_CLK_HZ, GAP_NS);
    localparam int CFG_SHIFT = RES_BITS - CFG_W;

    cfg_t                cfg_q;
    logic                merge_en;
    sel_t                merge_sel;
    logic                xfer_start;
    logic                xfer_zero;
    logic                xfer_done;
    logic [RES_BITS-1:0] xfer_rx;
    logic [RES_BITS-1:0] xfer_word;

    assign xfer_word = xfer_zero ? '0 : (RES_BITS'(cfg_q) << CFG_SHIFT);

    adc_cfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .merge_en  (merge_en),
        .merge_sel (merge_sel),
        .cfg_q     (cfg_q)
    );

    adc_seq_fsm #(
        .RES_BITS (RES_BITS),
        .NUM_CH   (NUM_CH)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ch     (req_ch),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_data   (rsp_data),
        .xfer_start (xfer_start),
        .xfer_zero  (xfer_zero),
        .xfer_done  (xfer_done),
        .xfer_rx    (xfer_rx),
        .merge_en   (merge_en),
        .merge_sel  (merge_sel)
    );

    adc_spi_word #(
        .W   (RES_BITS),
        .DIV (SCLK_DIV),
        .GAP (GAP_CYC)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (xfer_start),
        .tx_word (xfer_word),
        .done    (xfer_done),
        .rx_word (xfer_rx),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );
endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk #(
    parameter int RES_BITS = 16,
    parameter int NUM_CH   = 8,
    parameter int GAP_CYC  = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_ch,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       spi_sclk,
    input logic       spi_cs_n
);
    logic [15:0] high_cnt;
    logic [15:0] pulse_cnt;
    logic        sclk_d;
    logic        seen_xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt  <= '0;
            pulse_cnt <= '0;
            sclk_d    <= 1'b0;
            seen_xfer <= 1'b0;
        end else begin
            sclk_d <= spi_sclk;
            if (spi_cs_n) begin
                pulse_cnt <= '0;
                if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
            end else begin
                high_cnt  <= '0;
                seen_xfer <= 1'b1;
                if (spi_sclk && !sclk_d) pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R5

    AST_PULSES_PER_WORD: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && seen_xfer && pulse_cnt != 16'd0) |-> (int'(pulse_cnt) == RES_BITS)); // R5

    AST_GAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && seen_xfer && high_cnt != 16'd0) |-> (int'(high_cnt) >= GAP_CYC)); // R6

    AST_NOT_READY_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready); // R9

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9

    AST_BAD_CH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && int'(req_ch) >= NUM_CH) |=> (rsp_valid && rsp_err && spi_cs_n)); // R8
endmodule

bind adc_chan_seq adc_chan_seq_chk #(
    .RES_BITS (RES_BITS),
    .NUM_CH   (NUM_CH),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/adc_chan_seq_test.sv
`timescale 1ns/1ps
module adc_chan_seq_test;
    localparam int RES     = 16;
    localparam int NCH     = 6;
    localparam int GAP_EXP = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic [2:0]     req_ch = '0;
    logic           req_ready, rsp_valid, rsp_err;
    logic [RES-1:0] rsp_data;
    logic           spi_sclk, spi_cs_n, spi_mosi;
    logic           spi_miso = 1'b0;

    always #2 clk = ~clk;

    adc_chan_seq #(
        .RES_BITS(RES), .NUM_CH(NCH), .SCLK_DIV(2),
        .SYS_CLK_HZ(250_000_000), .GAP_NS(20)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ch(req_ch),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: a word written in transfer k selects the input of the
    // acquisition after k, whose result is shifted out in transfer k+2.
    int             xfer_total = 0;
    int             pulses = 0;
    int             bad_pulses = 0;
    int             gap_cnt = 0;
    int             min_gap = 1000;
    int             sclk_bad = 0;
    logic [RES-1:0] wlog [0:1023];
    logic [RES-1:0] slog [0:1023];
    logic [RES-1:0] dev_rx = '0;
    logic [RES-1:0] dev_tx = '0;
    logic [RES-1:0] out_next = '0;
    logic [RES-1:0] sent = '0;
    logic [2:0]     cur_sel = '0;
    logic [2:0]     acq_sel = '0;
    logic [12:0]    acq_seq = 13'd1;
    logic [13:0]    rx_cfg;

    always @(negedge spi_cs_n) begin
        if (xfer_total > 0 && gap_cnt < min_gap) min_gap = gap_cnt;
        sent     = out_next;
        dev_tx   = out_next;
        spi_miso = dev_tx[RES-1];
        pulses   = 0;
        dev_rx   = '0;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        dev_rx = {dev_rx[RES-2:0], spi_mosi};
        pulses++;
    end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        dev_tx   = dev_tx << 1;
        spi_miso = dev_tx[RES-1];
    end
    always @(posedge spi_cs_n) if (pulses > 0) begin
        if (pulses != RES) bad_pulses++;
        wlog[xfer_total % 1024] = dev_rx;
        slog[xfer_total % 1024] = sent;
        xfer_total++;
        out_next = {acq_sel, acq_seq};
        acq_seq  = acq_seq + 13'd1;
        rx_cfg   = dev_rx[RES-1 -: 14];
        if (rx_cfg[13]) cur_sel = rx_cfg[9:7];
        acq_sel  = cur_sel;
        pulses   = 0;
    end
    always @(negedge clk) begin
        if (spi_cs_n) gap_cnt++; else gap_cnt = 0;
        if (spi_cs_n === 1'b1 && spi_sclk === 1'b1) sclk_bad++;
    end

    function automatic logic [RES-1:0] cfg_word(input logic [2:0] ch);
        logic [13:0] c;
        c = (14'h3C79 & ~14'h0380) | (14'(ch) << 7);
        return {c, 2'b00};
    endfunction

    logic [2:0] last_exp = 3'd0;

    task automatic do_read(input logic [2:0] ch, input bit hammer);
        int base, nx, en;
        logic           got_err;
        logic [RES-1:0] got_data;
        while (!req_ready) @(negedge clk);
        base      = xfer_total;
        req_valid = 1'b1;
        req_ch    = ch;
        @(negedge clk);
        if (hammer) begin
            req_ch = ch ^ 3'd1;
            repeat (8) @(negedge clk);
        end
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_err  = rsp_err;
        got_data = rsp_data;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 rsp_valid single pulse", 32'(rsp_valid), 0);
        nx = xfer_total - base;
        if (int'(ch) >= NCH) begin
            chk(got_err == 1'b1, "R8 error flag", 32'(got_err), 1);
            chk(nx == 0, "R8 no transfer", 32'(nx), 0);
        end else begin
            en = (ch == last_exp) ? 2 : 3;
            chk(got_err == 1'b0, "R7 no error", 32'(got_err), 0);
            if (en == 2) chk(nx == en, "R2 same-input count", 32'(nx), 32'(en));
            else         chk(nx == en, "R3 new-input count", 32'(nx), 32'(en));
            for (int k = 0; k < en - 1; k++)
                chk(wlog[(base + k) % 1024] == cfg_word(ch), "R4 config word",
                    32'(wlog[(base + k) % 1024]), 32'(cfg_word(ch)));
            chk(wlog[(xfer_total - 1) % 1024] == '0, "R5 zero data word",
                32'(wlog[(xfer_total - 1) % 1024]), 0);
            chk(got_data == slog[(xfer_total - 1) % 1024], "R7 result word",
                32'(got_data), 32'(slog[(xfer_total - 1) % 1024]));
            chk(got_data[RES-1 -: 3] == ch, "R7 result input tag",
                32'(got_data[RES-1 -: 3]), 32'(ch));
            last_exp = ch;
        end
        if (hammer) begin
            base = xfer_total;
            repeat (100) @(negedge clk);
            chk(xfer_total == base, "R9 held request ignored", 32'(xfer_total), 32'(base));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 reset cs_n", 32'(spi_cs_n), 1);
        chk(req_ready == 1'b0, "R1 reset ready", 32'(req_ready), 0);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk(spi_sclk == 1'b0, "R5 reset sclk", 32'(spi_sclk), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 not ready during start-up", 32'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        chk(xfer_total == 5, "R1 start-up transfer count", 32'(xfer_total), 5);
        chk(wlog[0] == {14'h3C79, 2'b00}, "R1 boot word", 32'(wlog[0]), 32'h3C79 << 2);
        chk(wlog[1] == cfg_word(3'd0), "R1 read cfg", 32'(wlog[1]), 32'(cfg_word(3'd0)));
        chk(wlog[2] == '0, "R1 read data", 32'(wlog[2]), 0);
        chk(wlog[3] == cfg_word(3'd0), "R1 read cfg", 32'(wlog[3]), 32'(cfg_word(3'd0)));
        chk(wlog[4] == '0, "R1 read data", 32'(wlog[4]), 0);

        for (int a = 0; a < NCH; a++) begin
            for (int b = 0; b < 8; b++) begin
                do_read(3'(a), 1'b0);
                do_read(3'(b), 1'b0);
            end
        end

        // R10: rejected request keeps the last-input record
        do_read(3'd2, 1'b0);
        do_read(3'd7, 1'b0);
        do_read(3'd2, 1'b0);
        do_read(3'd6, 1'b0);
        do_read(3'd4, 1'b0);
        chk(last_exp == 3'd4, "R10 last input", 32'(last_exp), 4);

        do_read(3'd4, 1'b1);
        do_read(3'd1, 1'b1);

        chk(min_gap >= GAP_EXP, "R6 idle gap", 32'(min_gap), GAP_EXP);
        chk(bad_pulses == 0, "R5 pulses per transfer", 32'(bad_pulses), 0);
        chk(sclk_bad == 0, "R5 sclk idle low", 32'(sclk_bad), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule